// File: doc/BRIEF.md
# Cascaded Interrupt Controller Command Front End

This block is the register side of a master/slave pair of interrupt controllers. Each controller owns two I/O ports: a command port at its base address and a data port at base plus one. Bytes written there are sorted into initialization words and operation words. The block keeps the resulting configuration in registers: the line mask, the vector base, the cascade and mode words, the special mask and poll flags, and the choice between request and in-service state for status reads. It also issues a one-cycle end-of-interrupt strobe. All of this is handed to an external priority resolver, which this block does not contain.

Initialization always uses four bytes. A command-port byte with bit 4 set starts the sequence, and the next three data-port bytes complete it. After that, the data port carries the mask, and command-port bytes with bit 4 clear carry the end-of-interrupt/rotation command or the read/mode-select command.

Level or edge sensing for each of the 16 lines comes from a separate two-byte trigger register. The trigger bit inside the first initialization byte has no effect.

Top module: `irq_cmd_frontend`

## Requirements
- R1: A write to a controller's command port (master 020h, slave 0A0h) with data bit 4 set restarts that controller's initialization. In the next cycle, init_done is 0, the mask is 00h, and special mask, poll, ISR select and rotate-on-auto-EOI are all 0.
- R2: After that restart, the next three writes to base plus one are stored in order. The first stores data bits 7:3 as the vector base, the second stores the cascade byte, and the third stores the mode byte. init_done rises in the cycle after the third write.
- R3: The controller ports are 020h/021h (master) and 0A0h/0A1h (slave). The full 16-bit address is decoded, so writes to any other address, such as 022h or 120h, change no controller state.
- R4: Once init_done is 1, a write to base plus one loads the 8-bit mask, where a 1 masks the matching line. Before the first restart after reset, data-port writes are ignored.
- R5: With init_done at 1, a command-port write with bit 4 = 0 and bit 3 = 0 pulses eoi_valid for exactly one cycle. In that cycle, eoi_cmd carries data bits 7:5 and eoi_level carries bits 2:0. Command 100b sets rot_aeoi, and command 000b clears it.
- R6: With init_done at 1, a command-port write with bit 4 = 0 and bit 3 = 1 acts as a select command. If bit 1 is set, sel_isr takes bit 0 (1 selects ISR). If bit 6 is set, special_mask takes bit 5. poll_mode always takes bit 2.
- R7: Command-port writes with bit 4 = 0 are ignored while init_done is 0.
- R8: io_rdata is updated in the cycle after io_rd and holds otherwise. A read of the command port returns the IRR or ISR byte of that controller, as chosen by sel_isr. A read of base plus one returns the mask. A read of an unmapped address returns FFh. A command-port read clears poll_mode.
- R9: The trigger register sits at 04D0h (lines 7:0) and 04D1h (lines 15:8), where 1 means level. Lines 0, 1, 2, 8 and 13 always read 0. Bit 3 of a restart byte never changes this register.
- R10: After reset, init_done is 0, the mask is FFh, the trigger register is 0, eoi_valid is 0, sel_isr is 0 and io_rdata is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| irr_in | input | 16 | Request state from resolver (slave in 15:8) |
| isr_in | input | 16 | In-service state from resolver |
| irq_mask | output | 16 | Line masks, 1 = masked |
| trig_level | output | 16 | Per-line trigger, 1 = level |
| init_done | output | 2 | Initialization complete per controller |
| vec_base | output | 10 | Vector base, 5 bits per controller |
| casc_cfg | output | 16 | Cascade byte per controller |
| mode_cfg | output | 16 | Mode byte per controller |
| eoi_valid | output | 2 | End-of-interrupt/rotation strobe |
| eoi_cmd | output | 6 | Command field, 3 bits per controller |
| eoi_level | output | 6 | Level field, 3 bits per controller |
| rot_aeoi | output | 2 | Rotate on auto-EOI |
| special_mask | output | 2 | Special mask mode |
| poll_mode | output | 2 | Poll mode |
| sel_isr | output | 2 | Status read select, 1 = ISR |

## Verification
Random bursts mix complete four-byte initializations, stray data bytes, operation bytes with every bit 3/bit 4 combination, and trigger writes. This separates the sequencing state from the ready state, and it separates the two command-port decodes from each other. Directed cases probe operation bytes given before initialization (which must not leak), aliases that differ only in high address bits (which must not decode), and a restart byte with bit 3 set (which must leave the trigger register alone). Status reads with random request and in-service inputs show whether the select and poll-clear behaviour follows the latest select command.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  localparam int NUM_CTL = 2;
  localparam int DW      = 8;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_W2     = 3'd1,
    ST_W3     = 3'd2,
    ST_W4     = 3'd3,
    ST_READY  = 3'd4
  } init_st_t;

  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic rd_lo;
    logic rd_hi;
  } port_hit_t;

  localparam logic [2:0] CMD_ROT_SET = 3'b100;
  localparam logic [2:0] CMD_ROT_CLR = 3'b000;
endpackage

// File: rtl/irq_port_decode.sv
module irq_port_decode
  import irq_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MST_BASE  = 16'h0020,
  parameter logic [ADDR_W-1:0] SLV_BASE  = 16'h00A0,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 16'h04D0
) (
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  output port_hit_t [NUM_CTL-1:0]  hit,
  output logic [1:0]               trig_wr,
  output logic [1:0]               trig_rd
);
  for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
    localparam logic [ADDR_W-1:0] B0 = (g == 0) ? MST_BASE : SLV_BASE;
    localparam logic [ADDR_W-1:0] B1 = B0 + 1'b1;
    assign hit[g].wr_lo = io_wr && (io_addr == B0);
    assign hit[g].wr_hi = io_wr && (io_addr == B1);
    assign hit[g].rd_lo = io_rd && (io_addr == B0);
    assign hit[g].rd_hi = io_rd && (io_addr == B1);
  end

  for (genvar b = 0; b < 2; b++) begin : g_trig
    localparam logic [ADDR_W-1:0] TA = TRIG_BASE + ADDR_W'(b);
    assign trig_wr[b] = io_wr && (io_addr == TA);
    assign trig_rd[b] = io_rd && (io_addr == TA);
  end
endmodule

// File: rtl/irq_trig_reg.sv
module irq_trig_reg
  import irq_cmd_pkg::*;
#(
  parameter int LINES = 16,
  parameter logic [LINES-1:0] LOCKED = 16'h2107
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       wr,
  input  logic [DW-1:0]    wdata,
  output logic [LINES-1:0] trig_q
);
  for (genvar b = 0; b < 2; b++) begin : g_lane
    localparam logic [DW-1:0] LK = LOCKED[b*DW +: DW];
    always_ff @(posedge clk) begin
      if (rst)        trig_q[b*DW +: DW] <= '0;
      else if (wr[b]) trig_q[b*DW +: DW] <= wdata & ~LK;
    end

    p_trig_write_r9: assert property (@(posedge clk) disable iff (rst)
      wr[b] |=> trig_q[b*DW +: DW] == ($past(wdata) & ~LK));
  end

  p_trig_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr == 2'b00) |=> $stable(trig_q));
endmodule

// File: rtl/irq_ctl_unit.sv
module irq_ctl_unit
  import irq_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          rd_lo,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic          init_done,
  output logic [4:0]    vec_q,
  output logic [DW-1:0] casc_q,
  output logic [DW-1:0] mode_q,
  output logic          eoi_v_q,
  output logic [2:0]    eoi_cmd_q,
  output logic [2:0]    eoi_lvl_q,
  output logic          rot_q,
  output logic          smm_q,
  output logic          poll_q,
  output logic          sel_q
);
  init_st_t st;

  assign init_done = (st == ST_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_UNINIT;
      mask_q    <= '1;
      vec_q     <= '0;
      casc_q    <= '0;
      mode_q    <= '0;
      eoi_v_q   <= 1'b0;
      eoi_cmd_q <= '0;
      eoi_lvl_q <= '0;
      rot_q     <= 1'b0;
      smm_q     <= 1'b0;
      poll_q    <= 1'b0;
      sel_q     <= 1'b0;
    end else begin
      eoi_v_q <= 1'b0;
      if (rd_lo) poll_q <= 1'b0;
      if (wr_lo) begin
        if (wdata[4]) begin
          st     <= ST_W2;
          mask_q <= '0;
          smm_q  <= 1'b0;
          poll_q <= 1'b0;
          sel_q  <= 1'b0;
          rot_q  <= 1'b0;
        end else if (st == ST_READY) begin
          if (!wdata[3]) begin
            eoi_v_q   <= 1'b1;
            eoi_cmd_q <= wdata[7:5];
            eoi_lvl_q <= wdata[2:0];
            if (wdata[7:5] == CMD_ROT_SET)      rot_q <= 1'b1;
            else if (wdata[7:5] == CMD_ROT_CLR) rot_q <= 1'b0;
          end else begin
            if (wdata[1]) sel_q <= wdata[0];
            if (wdata[6]) smm_q <= wdata[5];
            poll_q <= wdata[2];
          end
        end
      end else if (wr_hi) begin
        case (st)
          ST_W2:    begin vec_q  <= wdata[7:3]; st <= ST_W3;    end
          ST_W3:    begin casc_q <= wdata;      st <= ST_W4;    end
          ST_W4:    begin mode_q <= wdata;      st <= ST_READY; end
          ST_READY: mask_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  p_restart_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && wdata[4]) |=> (!init_done && mask_q == '0 && !sel_q && !poll_q));

  p_third_write_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_W4 && wr_hi && !wr_lo) |=> init_done);

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_lo && !wr_hi) |=> $stable(mask_q));

  p_eoi_source_r5: assert property (@(posedge clk) disable iff (rst)
    eoi_v_q |-> $past(wr_lo && !wdata[4] && !wdata[3]));

  p_eoi_single_r5: assert property (@(posedge clk) disable iff (rst)
    eoi_v_q && !(wr_lo && !wdata[4] && !wdata[3]) |=> !eoi_v_q);

  p_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wdata[4] && !init_done && !rd_lo) |=>
      (!eoi_v_q && $stable(smm_q) && $stable(poll_q) && $stable(sel_q)));
endmodule

// File: rtl/irq_cmd_frontend.sv
module irq_cmd_frontend
  import irq_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] MST_BASE  = 16'h0020,
  parameter logic [ADDR_W-1:0] SLV_BASE  = 16'h00A0,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 16'h04D0,
  parameter logic [15:0]       TRIG_LOCK = 16'h2107
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [15:0]       irr_in,
  input  logic [15:0]       isr_in,
  output logic [15:0]       irq_mask,
  output logic [15:0]       trig_level,
  output logic [1:0]        init_done,
  output logic [9:0]        vec_base,
  output logic [15:0]       casc_cfg,
  output logic [15:0]       mode_cfg,
  output logic [1:0]        eoi_valid,
  output logic [5:0]        eoi_cmd,
  output logic [5:0]        eoi_level,
  output logic [1:0]        rot_aeoi,
  output logic [1:0]        special_mask,
  output logic [1:0]        poll_mode,
  output logic [1:0]        sel_isr
);
  port_hit_t [NUM_CTL-1:0] hit;
  logic [1:0]              trig_wr;
  logic [1:0]              trig_rd;
  logic [DW-1:0]           rd_next;

  irq_port_decode #(
    .ADDR_W(ADDR_W), .MST_BASE(MST_BASE), .SLV_BASE(SLV_BASE), .TRIG_BASE(TRIG_BASE)
  ) u_dec (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .hit(hit), .trig_wr(trig_wr), .trig_rd(trig_rd)
  );

  irq_trig_reg #(.LINES(16), .LOCKED(TRIG_LOCK)) u_trig (
    .clk(clk), .rst(rst), .wr(trig_wr), .wdata(io_wdata), .trig_q(trig_level)
  );

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_unit
    irq_ctl_unit u_ctl (
      .clk(clk), .rst(rst),
      .wr_lo(hit[g].wr_lo), .wr_hi(hit[g].wr_hi), .rd_lo(hit[g].rd_lo),
      .wdata(io_wdata),
      .mask_q(irq_mask[g*DW +: DW]),
      .init_done(init_done[g]),
      .vec_q(vec_base[g*5 +: 5]),
      .casc_q(casc_cfg[g*DW +: DW]),
      .mode_q(mode_cfg[g*DW +: DW]),
      .eoi_v_q(eoi_valid[g]),
      .eoi_cmd_q(eoi_cmd[g*3 +: 3]),
      .eoi_lvl_q(eoi_level[g*3 +: 3]),
      .rot_q(rot_aeoi[g]),
      .smm_q(special_mask[g]),
      .poll_q(poll_mode[g]),
      .sel_q(sel_isr[g])
    );
  end

  always_comb begin
    rd_next = '1;
    for (int c = 0; c < NUM_CTL; c++) begin
      if (hit[c].rd_lo) rd_next = sel_isr[c] ? isr_in[c*DW +: DW] : irr_in[c*DW +: DW];
      if (hit[c].rd_hi) rd_next = irq_mask[c*DW +: DW];
    end
    if (trig_rd[0]) rd_next = trig_level[7:0];
    if (trig_rd[1]) rd_next = trig_level[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_next;
  end

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));
endmodule

// File: tb/tb_irq_cmd_frontend.sv
module tb_irq_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] io_addr;
  logic        io_wr, io_rd;
  logic [7:0]  io_wdata, io_rdata;
  logic [15:0] irr_in, isr_in;
  logic [15:0] irq_mask, trig_level, casc_cfg, mode_cfg;
  logic [1:0]  init_done, eoi_valid, rot_aeoi, special_mask, poll_mode, sel_isr;
  logic [9:0]  vec_base;
  logic [5:0]  eoi_cmd, eoi_level;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // model state
  int         m_st   [2];
  logic [7:0] m_mask [2];
  logic [4:0] m_vec  [2];
  logic [7:0] m_casc [2];
  logic [7:0] m_mode [2];
  logic       m_eoi  [2];
  logic [2:0] m_cmd  [2];
  logic [2:0] m_lvl  [2];
  logic       m_rot  [2];
  logic       m_smm  [2];
  logic       m_poll [2];
  logic       m_sel  [2];
  logic [15:0] m_trig;

  always #5 clk = ~clk;

  irq_cmd_frontend dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irr_in(irr_in), .isr_in(isr_in),
    .irq_mask(irq_mask), .trig_level(trig_level), .init_done(init_done),
    .vec_base(vec_base), .casc_cfg(casc_cfg), .mode_cfg(mode_cfg),
    .eoi_valid(eoi_valid), .eoi_cmd(eoi_cmd), .eoi_level(eoi_level),
    .rot_aeoi(rot_aeoi), .special_mask(special_mask), .poll_mode(poll_mode),
    .sel_isr(sel_isr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of(int c);
    return (c == 0) ? 16'h0020 : 16'h00A0;
  endfunction

  task automatic mdl_reset();
    for (int c = 0; c < 2; c++) begin
      m_st[c] = 0; m_mask[c] = 8'hFF; m_vec[c] = 0; m_casc[c] = 0; m_mode[c] = 0;
      m_eoi[c] = 0; m_cmd[c] = 0; m_lvl[c] = 0; m_rot[c] = 0; m_smm[c] = 0;
      m_poll[c] = 0; m_sel[c] = 0;
    end
    m_trig = 16'h0000;
  endtask

  task automatic mdl_write(logic [15:0] a, logic [7:0] d);
    for (int c = 0; c < 2; c++) begin
      m_eoi[c] = 0;
      if (a == base_of(c)) begin
        if (d[4]) begin
          m_st[c] = 1; m_mask[c] = 0; m_smm[c] = 0; m_poll[c] = 0; m_sel[c] = 0; m_rot[c] = 0;
        end else if (m_st[c] == 4) begin
          if (!d[3]) begin
            m_eoi[c] = 1; m_cmd[c] = d[7:5]; m_lvl[c] = d[2:0];
            if (d[7:5] == 3'b100) m_rot[c] = 1;
            if (d[7:5] == 3'b000) m_rot[c] = 0;
          end else begin
            if (d[1]) m_sel[c] = d[0];
            if (d[6]) m_smm[c] = d[5];
            m_poll[c] = d[2];
          end
        end
      end else if (a == base_of(c) + 16'd1) begin
        case (m_st[c])
          1: begin m_vec[c] = d[7:3]; m_st[c] = 2; end
          2: begin m_casc[c] = d; m_st[c] = 3; end
          3: begin m_mode[c] = d; m_st[c] = 4; end
          4: m_mask[c] = d;
          default: ;
        endcase
      end
    end
    if (a == 16'h04D0) m_trig[7:0]  = d & 8'hF8;
    if (a == 16'h04D1) m_trig[15:8] = d & 8'hDE;
  endtask

  task automatic cmp_all();
    chk("R2 init_done",     {30'd0, init_done}, {30'd0, m_st[1] == 4, m_st[0] == 4});
    chk("R4 irq_mask",      {16'd0, irq_mask}, {16'd0, m_mask[1], m_mask[0]});
    chk("R2 vec_base",      {22'd0, vec_base}, {22'd0, m_vec[1], m_vec[0]});
    chk("R2 casc_cfg",      {16'd0, casc_cfg}, {16'd0, m_casc[1], m_casc[0]});
    chk("R2 mode_cfg",      {16'd0, mode_cfg}, {16'd0, m_mode[1], m_mode[0]});
    chk("R5 eoi_valid",     {30'd0, eoi_valid}, {30'd0, m_eoi[1], m_eoi[0]});
    chk("R5 eoi_cmd",       {26'd0, eoi_cmd}, {26'd0, m_cmd[1], m_cmd[0]});
    chk("R5 eoi_level",     {26'd0, eoi_level}, {26'd0, m_lvl[1], m_lvl[0]});
    chk("R5 rot_aeoi",      {30'd0, rot_aeoi}, {30'd0, m_rot[1], m_rot[0]});
    chk("R6 special_mask",  {30'd0, special_mask}, {30'd0, m_smm[1], m_smm[0]});
    chk("R6 poll_mode",     {30'd0, poll_mode}, {30'd0, m_poll[1], m_poll[0]});
    chk("R6 sel_isr",       {30'd0, sel_isr}, {30'd0, m_sel[1], m_sel[0]});
    chk("R9 trig_level",    {16'd0, trig_level}, {16'd0, m_trig});
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    mdl_write(a, d);
    cmp_all();
  endtask

  task automatic do_rd(logic [15:0] a);
    logic [7:0] exp;
    @(negedge clk);
    irr_in = 16'($urandom()); isr_in = 16'($urandom());
    exp = 8'hFF;
    for (int c = 0; c < 2; c++) begin
      if (a == base_of(c)) exp = m_sel[c] ? isr_in[c*8 +: 8] : irr_in[c*8 +: 8];
      if (a == base_of(c) + 16'd1) exp = m_mask[c];
    end
    if (a == 16'h04D0) exp = m_trig[7:0];
    if (a == 16'h04D1) exp = m_trig[15:8];
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    for (int c = 0; c < 2; c++) begin
      m_eoi[c] = 0;
      if (a == base_of(c)) m_poll[c] = 0;
    end
    chk("R8 io_rdata", {24'd0, io_rdata}, {24'd0, exp});
    chk("R8 poll_mode", {30'd0, poll_mode}, {30'd0, m_poll[1], m_poll[0]});
  endtask

  task automatic do_init(int c, logic [7:0] b1);
    do_wr(base_of(c), b1 | 8'h10);
    chk("R1 mask cleared", {24'd0, irq_mask[c*8 +: 8]}, 32'd0);
    do_wr(base_of(c) + 16'd1, 8'($urandom()));
    do_wr(base_of(c) + 16'd1, 8'($urandom()));
    do_wr(base_of(c) + 16'd1, 8'($urandom()));
    chk("R2 done after third", {31'd0, init_done[c]}, 32'd1);
  endtask

  initial begin
    logic [15:0] addrs [8];
    void'($urandom(32'd1234));
    addrs = '{16'h0020, 16'h0021, 16'h00A0, 16'h00A1, 16'h04D0, 16'h04D1, 16'h0022, 16'h0120};
    rst = 1'b1; io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0; irr_in = 0; isr_in = 0;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 init_done", {30'd0, init_done}, 32'd0);
    chk("R10 irq_mask", {16'd0, irq_mask}, 32'h0000FFFF);
    chk("R10 trig_level", {16'd0, trig_level}, 32'd0);
    chk("R10 eoi_valid", {30'd0, eoi_valid}, 32'd0);
    chk("R10 sel_isr", {30'd0, sel_isr}, 32'd0);
    chk("R10 io_rdata", {24'd0, io_rdata}, 32'd0);
    // R4: data port ignored before first restart
    do_wr(16'h0021, 8'h5A);
    // R7: op bytes before init ignored
    do_wr(16'h0020, 8'h20);
    do_wr(16'h0020, 8'h6F);
    do_rd(16'h0020);
    // R9: trigger writes, locked lines, restart bit 3 has no effect
    do_wr(16'h04D0, 8'hFF);
    do_wr(16'h04D1, 8'hFF);
    do_init(0, 8'h18);
    chk("R9 bit3 ignored", {16'd0, trig_level}, 32'h0000DEF8);
    do_init(1, 8'h11);
    // R7: op byte during sequence ignored
    do_wr(16'h00A0, 8'h10);
    do_wr(16'h00A1, 8'h40);
    do_wr(16'h00A0, 8'h60);
    chk("R7 no eoi mid-init", {30'd0, eoi_valid}, 32'd0);
    do_wr(16'h00A1, 8'h00);
    do_wr(16'h00A1, 8'h01);
    // R3: aliases
    do_wr(16'h0022, 8'h10);
    do_wr(16'h0120, 8'h10);
    chk("R3 alias no restart", {30'd0, init_done}, 32'd3);
    // R5/R6 directed
    do_wr(16'h0020, 8'h80);
    do_wr(16'h0020, 8'h0B);
    do_rd(16'h0020);
    do_wr(16'h0020, 8'h6C);
    do_rd(16'h0020);
    do_wr(16'h0020, 8'h00);
    // random phase
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) do_init($urandom_range(0, 1), 8'($urandom()));
      else if (k <= 2) do_rd(addrs[$urandom_range(0, 7)]);
      else begin
        logic [7:0] d = 8'($urandom());
        if ($urandom_range(0, 7) != 0) d[4] = 1'b0;
        do_wr(addrs[$urandom_range(0, 7)], d);
      end
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule